// File: doc/BRIEF.md
# Programmable-Latency Hit Frame Aligner

The aligner samples 48 discriminated hit lines and 48 bits of zero-suppressed fine-time data once per 40 MHz machine cycle. It packs them into a 112-bit frame together with a 16-bit header, and emits one frame on every cycle without gaps. The header holds a 12-bit bunch-crossing count and a 4-bit flag field.

Frames pass through a delay line whose length is set at run time. When several chips feed one serial link, each chip can be given its own delay so that frames for the same bunch crossing reach the link in the same cycle. A new delay is read only on a resync pulse. That pulse also empties the line, so the output carries zero frames until data assembled after the resync reaches it.

Top module: `hit_frame_aligner`

## Requirements
- R1: Frame bit layout: bits [111:100] carry the bunch-crossing count, bits [99:96] the flag input, bits [95:48] the hit inputs with channel i at bit 48+i, and bits [47:0] the fine-time input with bit i at bit i.
- R2: A frame assembled from the inputs present at clock edge E appears on `frame_o` right after edge E+D, where D is the active delay. One frame leaves per cycle, in assembly order.
- R3: Every delay value from 0 to 15 on the 4-bit `depth_i` is accepted, and each gives the latency stated in R2.
- R4: A change of `depth_i` while `resync_i` is low has no effect on latency or output.
- R5: On an edge with `resync_i` high, the active delay is loaded from `depth_i`, `frame_o` becomes all zero, and all frames held in the line are discarded, including the frame sampled at that edge. Zero frames follow until the first frame assembled after the resync arrives.
- R6: The bunch-crossing count advances by one per cycle and wraps from 4095 to 0.
- R7: When `bcr_i` is high at an edge, the frame sampled at the next edge carries count 0.
- R8: While `rst_n` is low at an edge, `frame_o` is zero, the active delay becomes 0 and the count becomes 0. The first frame sampled after release carries count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 48 | Discriminated hit lines, one per channel |
| fine_i | input | 48 | Zero-suppressed fine-time data |
| flag_i | input | 4 | Flag bits placed in the header |
| bcr_i | input | 1 | Bunch-counter reset |
| depth_i | input | 4 | Requested delay, read on resync |
| resync_i | input | 1 | Loads the delay and flushes the line |
| frame_o | output | 112 | Aligned output frame |

## Verification
The bench predicts every output frame from a history of the inputs it applied, and checks the output at the extreme delays 0 and 15 and at two values in between. A design with an off-by-one tap or a missing output stage would shift every frame by one cycle. A line that is not flushed on resync would leak stale frames instead of zeros. The bench also changes `depth_i` without a resync, which a design that reads the delay directly would obey, and it runs the counter across its wrap and through a bunch-counter reset.

// File: rtl/hfa_pkg.sv
// Package: shared widths and the frame layout for the hit frame aligner.
// Assumes: fields are packed from the most significant end in the order
// count, flags, hits, fine time.
package hfa_pkg;
    parameter int CHANNELS = 48;
    parameter int BX_W     = 12;
    parameter int FLAG_W   = 4;
    parameter int DEPTH_W  = 4;
    localparam int HDR_W   = BX_W + FLAG_W;
    localparam int FRAME_W = HDR_W + 2 * CHANNELS;

    typedef struct packed {
        logic [BX_W-1:0]     bx;
        logic [FLAG_W-1:0]   flags;
        logic [CHANNELS-1:0] hits;
        logic [CHANNELS-1:0] fine;
    } frame_t;
endpackage

// File: rtl/hfa_bx_counter.sv
// Bunch-crossing counter: counts machine cycles, wraps at its maximum and
// clears on a bunch-counter reset.
// Assumes: bcr_i is synchronous to clk and high for one cycle per reset.
module hfa_bx_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bcr_i,
    output logic [W-1:0] bx_o
);
    // Count one per cycle, return to zero on reset or bunch-counter reset.
    always_ff @(posedge clk) begin
        if (!rst_n || bcr_i) bx_o <= '0;
        else                 bx_o <= bx_o + 1'b1;
    end

    assert_bx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bcr_i |=> bx_o == '0);
    assert_bx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bcr_i |=> bx_o == W'($past(bx_o) + 1'b1));
endmodule

// File: rtl/hfa_frame_builder.sv
// Frame builder: packs header, hit and fine-time fields into one word.
// Assumes: all inputs belong to the same machine cycle. Purely combinational.
module hfa_frame_builder
    import hfa_pkg::*;
(
    input  logic [BX_W-1:0]     bx_i,
    input  logic [FLAG_W-1:0]   flag_i,
    input  logic [CHANNELS-1:0] hit_i,
    input  logic [CHANNELS-1:0] fine_i,
    output logic [FRAME_W-1:0]  word_o
);
    frame_t f;

    // Fill the frame fields from the inputs of this cycle.
    always_comb begin
        f.bx    = bx_i;
        f.flags = flag_i;
        f.hits  = hit_i;
        f.fine  = fine_i;
        word_o  = f;
    end
endmodule

// File: rtl/hfa_delay_line.sv
// Delay line: a shift line of 2**DEPTH_W-1 stages, a tap selected by the
// active delay, and one output register. Latency is the delay plus one.
// Assumes: resync_i is a single-cycle pulse. It loads the delay and clears
// every stage and the output.
module hfa_delay_line #(
    parameter int WIDTH   = 112,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               resync_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [WIDTH-1:0]   din,
    output logic [WIDTH-1:0]   dout
);
    localparam int NSTAGE = (1 << DEPTH_W) - 1;

    logic [DEPTH_W-1:0] depth_q;
    logic [WIDTH-1:0]   stage [NSTAGE];
    logic [WIDTH-1:0]   tap   [NSTAGE+1];

    // Take a new delay only on resync; go back to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        depth_q <= '0;
        else if (resync_i) depth_q <= depth_i;
    end

    // Shift the line one stage per cycle; flush it on reset or resync.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NSTAGE; k++) begin
            if (!rst_n || resync_i) stage[k] <= '0;
            else if (k == 0)        stage[k] <= din;
            else                    stage[k] <= stage[k-1];
        end
    end

    // Tap 0 is the undelayed word; tap k is the output of stage k-1.
    assign tap[0] = din;
    for (genvar k = 1; k <= NSTAGE; k++) begin : g_tap
        assign tap[k] = stage[k-1];
    end

    // Fixed output stage: register the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n || resync_i) dout <= '0;
        else                    dout <= tap[depth_q];
    end

    assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> dout == '0);
    assert_depth_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_i |=> $stable(depth_q));
    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_i |=> stage[0] == $past(din));
endmodule

// File: rtl/hit_frame_aligner.sv
// Hit frame aligner top: counts bunch crossings, builds a frame each cycle
// and sends it through the programmable delay line.
// Assumes: all inputs are synchronous to clk (the machine clock).
module hit_frame_aligner
    import hfa_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] hit_i,
    input  logic [CHANNELS-1:0] fine_i,
    input  logic [FLAG_W-1:0]   flag_i,
    input  logic                bcr_i,
    input  logic [DEPTH_W-1:0]  depth_i,
    input  logic                resync_i,
    output logic [FRAME_W-1:0]  frame_o
);
    logic [BX_W-1:0]    bx;
    logic [FRAME_W-1:0] word;

    hfa_bx_counter #(.W(BX_W)) u_bx (
        .clk   (clk),
        .rst_n (rst_n),
        .bcr_i (bcr_i),
        .bx_o  (bx)
    );

    hfa_frame_builder u_build (
        .bx_i   (bx),
        .flag_i (flag_i),
        .hit_i  (hit_i),
        .fine_i (fine_i),
        .word_o (word)
    );

    hfa_delay_line #(.WIDTH(FRAME_W), .DEPTH_W(DEPTH_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync_i (resync_i),
        .depth_i  (depth_i),
        .din      (word),
        .dout     (frame_o)
    );

    assert_reset_zero_R8: assert property (@(posedge clk)
        !rst_n |=> frame_o == '0);
endmodule

// File: tb/hit_frame_aligner_test.sv
module hit_frame_aligner_test;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [47:0]  hit_i = '0;
    logic [47:0]  fine_i = '0;
    logic [3:0]   flag_i = '0;
    logic         bcr_i = 0;
    logic [3:0]   depth_i = '0;
    logic         resync_i = 0;
    logic [111:0] frame_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_edge = 0;
    int r_edge = -1;
    int d_m = 0;
    logic [11:0]  bx_m = '0;
    logic [111:0] hist [32];

    hit_frame_aligner uut (.*);

    always #4 clk = ~clk;

    task automatic check(input logic [111:0] act, input logic [111:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: got %h expected %h", req, n_edge, act, exp);
        end
    endtask

    // One clock edge: update the model from the applied inputs, then compare.
    task automatic tick(input string req);
        logic [111:0] exp;
        if (!rst_n) begin
            r_edge = n_edge; d_m = 0; bx_m = '0; exp = '0;
        end else begin
            hist[n_edge % 32] = {bx_m, flag_i, hit_i, fine_i};
            if (resync_i) begin d_m = int'(depth_i); r_edge = n_edge; end
            exp = (n_edge - d_m > r_edge) ? hist[(n_edge - d_m) % 32] : '0;
            bx_m = bcr_i ? 12'd0 : bx_m + 12'd1;
        end
        @(posedge clk); #2;
        check(frame_o, exp, req);
        n_edge++;
    endtask

    task automatic vary(input int i);
        hit_i  = {16'(i * 7 + 1), 16'(i ^ 16'hA5A5), 16'(~i)};
        fine_i = {16'(i * 13), 16'(i + 3), 16'(i << 2)};
        flag_i = 4'(i);
    endtask

    task automatic set_depth(input int d, input string req);
        depth_i = 4'(d); resync_i = 1;
        tick(req);
        resync_i = 0;
    endtask

    // R8: outputs zero in reset, count starts at zero afterwards.
    task automatic t_reset();
        rst_n = 0; vary(5);
        for (int i = 0; i < 3; i++) tick("R8");
        rst_n = 1;
        for (int i = 0; i < 3; i++) begin vary(i); tick("R8"); end
    endtask

    // R1: field positions with single channels and alternating patterns.
    task automatic t_layout();
        set_depth(0, "R1");
        hit_i = 48'h1; fine_i = 48'h0; flag_i = 4'h1; tick("R1");
        hit_i = 48'h8000_0000_0000; fine_i = 48'h1; flag_i = 4'h8; tick("R1");
        hit_i = 48'h5555_5555_5555; fine_i = 48'hAAAA_AAAA_AAAA; tick("R1");
        hit_i = '0; fine_i = 48'h8000_0000_0000; flag_i = 4'hF; tick("R1");
        tick("R1");
    endtask

    // R2 and R3: latency for several delays including both extremes.
    task automatic t_latency(input int d);
        vary(d); set_depth(d, "R3");
        for (int i = 0; i < d + 6; i++) begin vary(i + 40); tick("R2"); end
    endtask

    // R4: depth input moves without resync and must be ignored.
    task automatic t_ignore();
        set_depth(3, "R4");
        for (int i = 0; i < 12; i++) begin
            vary(i + 90); depth_i = 4'(i * 5); tick("R4");
        end
    endtask

    // R5: resync in mid-stream flushes frames already in the line.
    task automatic t_resync();
        set_depth(6, "R5");
        for (int i = 0; i < 9; i++) begin vary(i + 200); tick("R5"); end
        vary(300); set_depth(6, "R5");
        for (int i = 0; i < 9; i++) begin vary(i + 310); tick("R5"); end
    endtask

    // R6: count runs across its wrap point.
    task automatic t_wrap();
        set_depth(2, "R6");
        for (int i = 0; i < 4110; i++) begin vary(i); tick("R6"); end
    endtask

    // R7: bunch-counter reset pulse in mid-stream.
    task automatic t_bcr();
        set_depth(1, "R7");
        for (int i = 0; i < 5; i++) begin vary(i); tick("R7"); end
        bcr_i = 1; tick("R7"); bcr_i = 0;
        for (int i = 0; i < 5; i++) begin vary(i + 7); tick("R7"); end
        bcr_i = 1; tick("R7"); bcr_i = 1; tick("R7"); bcr_i = 0;
        for (int i = 0; i < 4; i++) tick("R7");
    endtask

    initial begin
        #2;
        t_reset();
        t_layout();
        t_latency(0);
        t_latency(1);
        t_latency(7);
        t_latency(15);
        t_ignore();
        t_resync();
        t_wrap();
        t_bcr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule